// File: doc/BRIEF.md
# Direct-Mapped Instruction and Data Cache

This block places a single-word-per-line, direct-mapped cache between a processor port and a larger, slower main memory of 32K words, each 12 bits wide. The processor issues 15-bit word addresses. The low 9 bits pick one of 512 lines. Each line stores a 6-bit tag, a 12-bit data word and a valid flag. When the stored tag matches the upper address bits and the line is valid, a read is answered combinationally in the same cycle.

On a read miss the controller stalls the processor by holding `cpu_ready` low. It then fetches the word over a request/acknowledge memory port, passes it to the processor in the acknowledge cycle and installs it in the line together with the new tag. Writes always go through to main memory. A write also refreshes the cached copy when the line already holds that address. A write to an address that is not cached does not allocate a line. A one-cycle `flush` pulse invalidates every line at once.

The processor keeps `cpu_req` and its address and data stable until it sees `cpu_ready` high at a rising clock edge.

Top module: `dmc_cache`

## Requirements
- R1: The address is split as tag = `cpu_addr[14:9]` and line index = `cpu_addr[8:0]`. Two addresses hit the same line only if bits 8:0 are equal, and the same entry only if bits 14:9 are also equal.
- R2: After reset every line is invalid, so the first read of any address goes to main memory.
- R3: A read of a valid line whose tag matches returns the cached word with `cpu_ready` high in the same cycle as the request, and raises no `mem_req`.
- R4: A read miss raises `mem_req` with `mem_we` = 0 and `mem_addr` equal to the full 15-bit address. The controller asserts `cpu_ready` in the cycle where `mem_ack` is high, with `cpu_rdata` = `mem_rdata`. It fills the line, so the next read of that address hits.
- R5: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay constant until the cycle of `mem_ack`. `mem_req` is low in the cycle after `mem_ack`.
- R6: Every write raises `mem_req` with `mem_we` = 1, the full address and the write data, and completes in the `mem_ack` cycle. If the line holds that address, the cached word is updated, and a later hit returns the new value.
- R7: A write miss does not allocate a line: a later read of that address still misses.
- R8: A read miss to an address whose index matches a cached line but whose tag differs replaces that line, so the earlier address misses afterwards.
- R9: A `flush` pulse clears all valid flags in one cycle, and every address misses afterwards.
- R10: During and right after reset, `cpu_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate all lines in one cycle |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Word address: tag in 14:9, index in 8:0 |
| cpu_wdata | input | 12 | Write data |
| cpu_rdata | output | 12 | Read data, valid with cpu_ready on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Main memory request, held until mem_ack |
| mem_we | output | 1 | Main memory write strobe |
| mem_addr | output | 15 | Main memory word address |
| mem_wdata | output | 12 | Main memory write data |
| mem_rdata | input | 12 | Main memory read data, valid with mem_ack |
| mem_ack | input | 1 | Main memory completes the request this cycle |

## Verification
The assertions check the following on every cycle: the memory handshake holds its request fields until acknowledge and drops afterwards, a completion without memory involvement is always a read hit, every completed write is paired with a memory write acknowledge, and a flush leaves no valid line behind. Only the bench scenarios can show the data-dependent behaviour. That covers the tag/index split, line replacement on conflicting tags, write-miss non-allocation, refreshed data after a write hit, and the hit/miss pattern after reset and after a flush. For these, a reference model of tags and memory contents is compared against observed stall lengths and returned data.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_rst_sync.sv
module dmc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dmc_valid_bits.sv
module dmc_valid_bits #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] vld_d;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_set
      assign set_vec[i] = set_en && (set_idx == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    if (flush) vld_d = '0;
    else       vld_d = vld_q | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_valid = vld_q[rd_idx];

  // R9: a flush leaves every line invalid on the next cycle
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W = 9,
  parameter int W     = 18
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  localparam int LINES = 1 << IDX_W;

  logic [W-1:0] arr [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) arr[wr_idx] <= wr_data;
  end

  assign rd_data = arr[rd_idx];
endmodule

// File: rtl/dmc_ctrl_fsm.sv
module dmc_ctrl_fsm
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              lookup_hit,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] look_addr,
  output logic              cpu_ready,
  output logic              rdata_from_mem,
  output logic              fill_en,
  output logic              upd_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  dmc_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              load_en;

  always_comb begin
    state_d        = state_q;
    load_en        = 1'b0;
    cpu_ready      = 1'b0;
    rdata_from_mem = 1'b0;
    fill_en        = 1'b0;
    upd_en         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (cpu_we) begin
            load_en = 1'b1;
            state_d = ST_WR;
          end else if (lookup_hit) begin
            cpu_ready = 1'b1;
          end else begin
            load_en = 1'b1;
            state_d = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (mem_ack) begin
          cpu_ready      = 1'b1;
          rdata_from_mem = 1'b1;
          fill_en        = 1'b1;
          state_d        = ST_IDLE;
        end
      end
      ST_WR: begin
        if (mem_ack) begin
          cpu_ready = 1'b1;
          upd_en    = lookup_hit;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
  end

  assign look_addr = (state_q == ST_IDLE) ? cpu_addr : addr_q;
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R5: request fields frozen while waiting for the acknowledge
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R5: request dropped in the cycle after the acknowledge
  assert_req_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINE_W = TAG_W + DATA_W;

  logic              rst_n_s;
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              line_valid;
  logic [LINE_W-1:0] line_rd;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              lookup_hit;
  logic              rdata_from_mem;
  logic              fill_en;
  logic              upd_en;
  logic              store_we;
  logic [DATA_W-1:0] store_data;
  logic [LINE_W-1:0] store_line;

  dmc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign look_idx = look_addr[IDX_W-1:0];
  assign look_tag = look_addr[ADDR_W-1:IDX_W];

  dmc_valid_bits #(.IDX_W(IDX_W)) u_valid (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .flush    (flush),
    .set_en   (fill_en),
    .set_idx  (mem_addr[IDX_W-1:0]),
    .rd_idx   (look_idx),
    .rd_valid (line_valid)
  );

  assign store_we   = fill_en || upd_en;
  assign store_data = fill_en ? mem_rdata : mem_wdata;
  assign store_line = {mem_addr[ADDR_W-1:IDX_W], store_data};

  dmc_line_store #(.IDX_W(IDX_W), .W(LINE_W)) u_store (
    .clk     (clk),
    .wr_en   (store_we),
    .wr_idx  (mem_addr[IDX_W-1:0]),
    .wr_data (store_line),
    .rd_idx  (look_idx),
    .rd_data (line_rd)
  );

  assign line_tag   = line_rd[LINE_W-1:DATA_W];
  assign line_data  = line_rd[DATA_W-1:0];
  assign lookup_hit = line_valid && (line_tag == look_tag);

  dmc_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cpu_req        (cpu_req),
    .cpu_we         (cpu_we),
    .cpu_addr       (cpu_addr),
    .cpu_wdata      (cpu_wdata),
    .lookup_hit     (lookup_hit),
    .mem_ack        (mem_ack),
    .look_addr      (look_addr),
    .cpu_ready      (cpu_ready),
    .rdata_from_mem (rdata_from_mem),
    .fill_en        (fill_en),
    .upd_en         (upd_en),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata)
  );

  assign cpu_rdata = rdata_from_mem ? mem_rdata : line_data;

  // R3: a completion without memory acknowledge must be a read hit
  assert_fast_path_hit_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_ready && !mem_ack) |-> (cpu_req && !cpu_we && lookup_hit && !mem_req));

  // R6: a completed write always goes through to main memory
  assert_write_through_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_ready && cpu_req && cpu_we) |-> (mem_req && mem_we && mem_ack && mem_addr == cpu_addr));
endmodule

// File: tb/dmc_cache_test.sv
module dmc_cache_test;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        cpu_req, cpu_we;
  logic [14:0] cpu_addr;
  logic [11:0] cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [11:0] mem_wdata, mem_rdata;
  logic        mem_ack;

  int nchk = 0;
  int nfail = 0;
  int mem_rd_cnt = 0;
  int mem_wr_cnt = 0;
  int lat_cnt = 0;
  logic [14:0] last_mem_addr;
  logic [11:0] bmem [int];
  bit          mv [512];
  logic [5:0]  mt [512];

  always #2 clk = ~clk;

  dmc_cache uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [11:0] mem_read(input logic [14:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return 12'(int'(a) * 37) ^ 12'h5A3;
  endfunction

  // main memory model with a fixed latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt == LAT - 1) begin
        mem_ack <= 1'b1;
        lat_cnt <= 0;
        last_mem_addr <= mem_addr;
        if (mem_we) begin
          bmem[int'(mem_addr)] = mem_wdata;
          mem_wr_cnt <= mem_wr_cnt + 1;
        end else begin
          mem_rdata <= mem_read(mem_addr);
          mem_rd_cnt <= mem_rd_cnt + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string rq, input string what, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, got, exp);
    end
  endtask

  task automatic do_op(input bit we, input logic [14:0] a, input logic [11:0] d, input string rq);
    int stall;
    int rd0, wr0;
    bit hexp;
    logic [11:0] exp_d, got_d;
    hexp  = mv[a[8:0]] && (mt[a[8:0]] == a[14:9]);
    exp_d = mem_read(a);
    rd0 = mem_rd_cnt;
    wr0 = mem_wr_cnt;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    stall = 0;
    #1;
    while (!cpu_ready && stall < 40) begin
      @(negedge clk); #1;
      stall++;
    end
    got_d = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    @(negedge clk); #1;
    chk(rq, "stall cycles", stall, (!we && hexp) ? 0 : LAT + 1);
    if (!we) begin
      chk(rq, "read data", int'(got_d), int'(exp_d));
      chk(rq, "memory reads", mem_rd_cnt - rd0, hexp ? 0 : 1);
      if (!hexp) begin
        chk(rq, "miss address", int'(last_mem_addr), int'(a));
        mv[a[8:0]] = 1'b1;
        mt[a[8:0]] = a[14:9];
      end
    end else begin
      chk(rq, "memory writes", mem_wr_cnt - wr0, 1);
      chk(rq, "write address", int'(last_mem_addr), int'(a));
      chk(rq, "memory content", int'(mem_read(a)), int'(d));
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 512; i++) mv[i] = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [14:0] ra;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; flush = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R10", "cpu_ready in reset", int'(cpu_ready), 0);
    chk("R10", "mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "cpu_ready after reset", int'(cpu_ready), 0);
    chk("R10", "mem_req after reset", int'(mem_req), 0);

    do_op(1'b0, 15'h0000, '0, "R2");   // first read misses
    do_op(1'b0, 15'h0000, '0, "R3");   // same address hits
    do_op(1'b0, 15'h0200, '0, "R8");   // tag 1 index 0 replaces
    do_op(1'b0, 15'h0000, '0, "R8");   // earlier tag now misses
    do_op(1'b0, 15'h7FFF, '0, "R1");   // tag 3F index 1FF
    do_op(1'b0, 15'h01FF, '0, "R1");   // tag 0 index 1FF misses
    do_op(1'b0, 15'h7E00, '0, "R1");   // tag 3F index 0 misses
    do_op(1'b0, 15'h0005, '0, "R4");   // fill
    do_op(1'b0, 15'h0005, '0, "R4");   // hit after fill
    do_op(1'b1, 15'h0005, 12'hABC, "R6");
    do_op(1'b0, 15'h0005, '0, "R6");   // hit returns new data
    do_op(1'b1, 15'h0123, 12'h3C5, "R7");
    do_op(1'b0, 15'h0123, '0, "R7");   // still a miss
    do_flush();
    do_op(1'b0, 15'h0005, '0, "R9");   // misses after flush
    do_op(1'b0, 15'h7E00, '0, "R9");

    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 100);
      ra = {4'(0), 2'($urandom % 4), 5'(0), 4'($urandom % 16)};
      if (r < 3) ra = 15'($urandom);
      if (r < 2) do_flush();
      else if (r < 30) do_op(1'b1, ra, 12'($urandom), "R6");
      else do_op(1'b0, ra, '0, "R4");
    end

    finish_run();
  end
endmodule